// File: doc/BRIEF.md
# Subtract and Compare Arithmetic Unit with Decimal Correction

This block is the subtract side of a small accumulator processor's arithmetic unit. A combinational core takes an operand byte, the current accumulator byte and the current carry. It forms either a subtract-with-borrow or a compare, and produces a new accumulator value, a write enable, and new negative, zero, carry and overflow flags, each with its own update enable. In subtract mode a decimal flag switches the accumulator result to packed BCD correction. The flags still come from the plain binary difference.

A registered wrapper latches the core's results into an accumulator register and four flag registers when a valid strobe is high. Each register is written only when its update enable is set. The surrounding datapath presents the accumulator and carry values to use for the next operation. Instruction decode, addressing, cycle timing and the program counter belong elsewhere.

Top module: `sbc_cmp_unit`

## Requirements
- R1: After a synchronous active-high reset, the accumulator register and all four flag registers read zero.
- R2: With `op_cmp`=0 (subtract) and `dec_mode`=0, a valid strobe loads the accumulator with the low 8 bits of `acc_in - operand - (carry_in ? 0 : 1)`.
- R3: After a subtract or a compare, the carry flag is 1 exactly when the full-width difference did not go below zero (no borrow), and 0 otherwise.
- R4: The negative flag is bit 7 of the low byte of the binary difference. The zero flag is 1 when that byte is 0x00.
- R5: After a subtract, the overflow flag is 1 when bit 7 of `acc_in` differs both from bit 7 of the binary result and from bit 7 of `operand`.
- R6: With `op_cmp`=1 (compare), the difference is `acc_in - operand` with no borrow-in, whatever `carry_in` is. Its carry, negative and zero flags equal those of a subtract with `carry_in`=1.
- R7: A compare leaves the accumulator register and the overflow flag at their previous values.
- R8: For a subtract with `dec_mode`=1, the low digit is `acc_in[3:0] - operand[3:0] - borrow`. If that goes negative, 6 is taken from the digit (modulo 16) and an extra 0x10 is taken from the high-digit difference.
- R9: For a subtract with `dec_mode`=1, if the combined intermediate is negative after the high-digit step (bit 8 set), 0x60 is taken away before the low byte is written to the accumulator.
- R10: In decimal mode the carry, negative, zero and overflow flags are the same as for a binary subtract of the same inputs.
- R11: A compare ignores `dec_mode` and always uses the binary difference.
- R12: While `valid` is 0, the accumulator and all flag registers keep their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Latch this cycle's result |
| op_cmp | input | 1 | 0 = subtract with borrow, 1 = compare |
| dec_mode | input | 1 | Decimal (BCD) correction for subtract |
| acc_in | input | 8 | Accumulator value used as the minuend |
| carry_in | input | 1 | Current carry flag (1 = no borrow) |
| operand | input | 8 | Subtrahend byte |
| acc_q | output | 8 | Registered accumulator |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
A vector table covers the cases that separate the paths. Equal operands exercise the zero flag. Crossings of the signed boundary in both directions separate the overflow rule from the negative flag. A clear carry-in on subtract and a compare issued with carry clear show whether the borrow-in is taken or ignored. In decimal mode, a borrow out of only the low digit and a borrow through both digits drive the two correction steps separately. The table also runs a compare in decimal mode to show the correction is bypassed. A strided sweep then runs every accumulator value against many operands, with both carries and both modes, against an independent model. It tracks held values across compares. Directed tests cover reset and an idle strobe.

// File: rtl/sbc_cmp_pkg.sv
package sbc_cmp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    OP_SBC = 1'b0,
    OP_CMP = 1'b1
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/sbc_bin_sub.sv
// Binary subtractor with one guard bit; produces status from the raw difference.
module sbc_bin_sub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         borrow_in,
  output logic [W-1:0] diff,
  output logic         no_borrow,
  output logic         neg,
  output logic         zero,
  output logic         ovf
);
  logic [W:0] full;

  always_comb begin
    full      = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, borrow_in};
    diff      = full[W-1:0];
    no_borrow = ~full[W];
    neg       = full[W-1];
    zero      = (full[W-1:0] == '0);
    ovf       = (a[W-1] ^ full[W-1]) & (a[W-1] ^ b[W-1]);
  end
endmodule

// File: rtl/sbc_bcd_adjust.sv
// Two-digit packed BCD subtract correction. The intermediate carries two guard bits
// so that bit W marks a negative combined value.
module sbc_bcd_adjust #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         borrow_in,
  output logic [W-1:0] result
);
  localparam int unsigned DIG_W = W / 2;
  localparam int unsigned IW    = W + 2;
  localparam logic [IW-1:0] HI_BORROW = IW'(1) << DIG_W;
  localparam logic [IW-1:0] HI_FIX    = IW'(6) << DIG_W;

  logic [DIG_W:0]   lo_raw;
  logic [DIG_W-1:0] lo_fix;
  logic [IW-1:0]    hi_raw;
  logic [IW-1:0]    merged;
  logic [IW-1:0]    fixed;

  always_comb begin
    lo_raw = {1'b0, a[DIG_W-1:0]} - {1'b0, b[DIG_W-1:0]} - {{DIG_W{1'b0}}, borrow_in};
    // R8: digit borrow -> subtract 6 and borrow from the high digit
    lo_fix = lo_raw[DIG_W] ? (lo_raw[DIG_W-1:0] - DIG_W'(6)) : lo_raw[DIG_W-1:0];
    hi_raw = {2'b00, a[W-1:DIG_W], {DIG_W{1'b0}}}
           - {2'b00, b[W-1:DIG_W], {DIG_W{1'b0}}}
           - (lo_raw[DIG_W] ? HI_BORROW : '0);
    merged = hi_raw | {{(IW-DIG_W){1'b0}}, lo_fix};
    // R9: negative combined value -> take 0x60
    fixed  = merged[W] ? (merged - HI_FIX) : merged;
    result = fixed[W-1:0];
  end
endmodule

// File: rtl/sbc_cmp_core.sv
// Combinational subtract/compare unit: result, write enable, flags and flag enables.
module sbc_cmp_core
  import sbc_cmp_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  alu_op_e      op,
  input  logic         dec_mode,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] operand,
  input  logic         carry_in,
  output logic [W-1:0] acc_next,
  output logic         acc_we,
  output flags_t       flags_next,
  output flags_t       flags_we
);
  logic         borrow;
  logic         use_bcd;
  logic [W-1:0] bin_diff;
  logic [W-1:0] bcd_res;
  logic         nb, ng, zr, ov;

  // R6: compare has an implied carry of one
  assign borrow  = (op == OP_CMP) ? 1'b0 : ~carry_in;
  // R11: decimal correction only on subtract
  assign use_bcd = dec_mode && (op == OP_SBC);

  sbc_bin_sub #(.W(W)) u_bin (
    .a(acc_in), .b(operand), .borrow_in(borrow),
    .diff(bin_diff), .no_borrow(nb), .neg(ng), .zero(zr), .ovf(ov)
  );

  generate
    if (W == 8) begin : g_bcd
      sbc_bcd_adjust #(.W(W)) u_bcd (
        .a(acc_in), .b(operand), .borrow_in(borrow), .result(bcd_res)
      );
    end else begin : g_no_bcd
      assign bcd_res = bin_diff;
    end
  endgenerate

  always_comb begin
    acc_next     = use_bcd ? bcd_res : bin_diff;
    acc_we       = (op == OP_SBC);
    // R10: flags always from the binary difference
    flags_next.n = ng;
    flags_next.z = zr;
    flags_next.c = nb;
    flags_next.v = ov;
    flags_we.n   = 1'b1;
    flags_we.z   = 1'b1;
    flags_we.c   = 1'b1;
    flags_we.v   = (op == OP_SBC); // R7
  end

  // R7: compare never asks for an accumulator write
  always_comb begin
    if (!$isunknown(op)) begin
      a_r7_cmp_no_write: assert (!(op == OP_CMP && acc_we));
    end
  end
endmodule

// File: rtl/sbc_cmp_unit.sv
// Registered wrapper: latches accumulator and flags on a valid strobe.
module sbc_cmp_unit
  import sbc_cmp_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic         op_cmp,
  input  logic         dec_mode,
  input  logic [W-1:0] acc_in,
  input  logic         carry_in,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc_q,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  alu_op_e      op;
  logic [W-1:0] acc_next;
  logic         acc_we;
  flags_t       fl_next, fl_we, fl_q;

  assign op = op_cmp ? OP_CMP : OP_SBC;

  sbc_cmp_core #(.W(W)) u_core (
    .op(op), .dec_mode(dec_mode), .acc_in(acc_in), .operand(operand),
    .carry_in(carry_in), .acc_next(acc_next), .acc_we(acc_we),
    .flags_next(fl_next), .flags_we(fl_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      fl_q  <= '0;
    end else if (valid) begin
      if (acc_we)  acc_q   <= acc_next;
      if (fl_we.n) fl_q.n  <= fl_next.n;
      if (fl_we.z) fl_q.z  <= fl_next.z;
      if (fl_we.c) fl_q.c  <= fl_next.c;
      if (fl_we.v) fl_q.v  <= fl_next.v;
    end
  end

  assign flag_n = fl_q.n;
  assign flag_z = fl_q.z;
  assign flag_c = fl_q.c;
  assign flag_v = fl_q.v;

  a_r7_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    valid && op_cmp |=> $stable(acc_q));
  a_r7_cmp_keeps_v: assert property (@(posedge clk) disable iff (rst)
    valid && op_cmp |=> $stable(flag_v));
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable({acc_q, flag_n, flag_z, flag_c, flag_v}));
  a_r6_cmp_carry: assert property (@(posedge clk) disable iff (rst)
    valid && op_cmp |=> flag_c == ($past(acc_in) >= $past(operand)));
  a_r6_cmp_zero: assert property (@(posedge clk) disable iff (rst)
    valid && op_cmp |=> flag_z == ($past(acc_in) == $past(operand)));
endmodule

// File: tb/tb_sbc_cmp_unit.sv
module tb_sbc_cmp_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       valid = 1'b0;
  logic       op_cmp = 1'b0;
  logic       dec_mode = 1'b0;
  logic [7:0] acc_in = '0;
  logic       carry_in = 1'b0;
  logic [7:0] operand = '0;
  logic [7:0] acc_q;
  logic       flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sbc_cmp_unit dut (
    .clk(clk), .rst(rst), .valid(valid), .op_cmp(op_cmp), .dec_mode(dec_mode),
    .acc_in(acc_in), .carry_in(carry_in), .operand(operand), .acc_q(acc_q),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // {op_cmp, dec, cin, a, b, exp_acc, exp_nzcv}
  typedef struct packed {
    logic       cmp;
    logic       dec;
    logic       cin;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] acc;
    logic [3:0] nzcv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 1'b1, 8'h50, 8'h30, 8'h20, 4'b0010}, // R2 R3 plain
    '{1'b0, 1'b0, 1'b1, 8'h50, 8'hB0, 8'hA0, 4'b1001}, // R5 overflow, borrow
    '{1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 8'hFE, 4'b1000}, // R2 borrow-in used
    '{1'b0, 1'b0, 1'b1, 8'h80, 8'h01, 8'h7F, 4'b0011}, // R5 down across sign
    '{1'b1, 1'b0, 1'b1, 8'h10, 8'h20, 8'h7F, 4'b1001}, // R7 cmp holds acc and V
    '{1'b0, 1'b0, 1'b1, 8'h42, 8'h42, 8'h00, 4'b0110}, // R4 zero
    '{1'b0, 1'b1, 1'b1, 8'h46, 8'h12, 8'h34, 4'b0010}, // R10 decimal, no fix
    '{1'b0, 1'b1, 1'b1, 8'h40, 8'h13, 8'h27, 4'b0010}, // R8 low digit fix
    '{1'b0, 1'b1, 1'b1, 8'h00, 8'h01, 8'h99, 4'b1000}, // R9 both digits fix
    '{1'b0, 1'b1, 1'b0, 8'h10, 8'h10, 8'h99, 4'b1000}, // R8 R9 via borrow-in
    '{1'b1, 1'b1, 1'b0, 8'h40, 8'h13, 8'h99, 4'b0010}, // R11 cmp ignores dec, R6
    '{1'b1, 1'b0, 1'b0, 8'h7F, 8'h7F, 8'h99, 4'b0110}  // R6 cmp equal, carry ignored
  };

  task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got acc/nzcv %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(bit v, bit c, bit d, bit ci, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    valid = v; op_cmp = c; dec_mode = d; carry_in = ci; acc_in = a; operand = b;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] model(bit c, bit d, bit ci, int a, int b,
                                        logic [7:0] pacc, bit pv);
    int bw, bin, r8, lo, hi, t;
    logic [7:0] res;
    bit n, z, cy, v;
    bw  = (c || ci) ? 0 : 1;
    bin = a - b - bw;
    cy  = (bin >= 0);
    r8  = bin & 255;
    n   = (r8 >= 128);
    z   = (r8 == 0);
    v   = (((a ^ r8) & (a ^ b) & 128) != 0);
    res = 8'(r8);
    if (d && !c) begin
      lo = (a % 16) - (b % 16) - bw;
      hi = (a / 16) * 16 - (b / 16) * 16;
      if (lo < 0) begin
        lo = (lo - 6) & 15;
        hi = hi - 16;
      end
      t = hi + lo;
      if (t < 0) t = t - 96;
      res = 8'(t & 255);
    end
    if (c) return {pacc, n, z, cy, pv};
    return {res, n, z, cy, v};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] eacc;
    bit         ev;
    logic [11:0] exp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset state", {acc_q, flag_n, flag_z, flag_c, flag_v}, 12'h000);

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, TBL[i].cmp, TBL[i].dec, TBL[i].cin, TBL[i].a, TBL[i].b);
      check($sformatf("table %0d R2-family", i),
            {acc_q, flag_n, flag_z, flag_c, flag_v}, {TBL[i].acc, TBL[i].nzcv});
    end

    // R12: idle strobe with active-looking inputs changes nothing
    apply(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h01);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h55);
    check("R12 idle hold", {acc_q, flag_n, flag_z, flag_c, flag_v}, {8'h99, 4'b0110});

    // Sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 against the model
    eacc = 8'h99;
    ev   = 1'b0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 7) begin
        for (int m = 0; m < 5; m++) begin
          bit c  = (m == 4);
          bit d  = c ? bit'((a ^ b) & 1) : bit'(m / 2);
          bit ci = c ? bit'((a >> 1) & 1) : bit'(m % 2);
          exp = model(c, d, ci, a, b, eacc, ev);
          apply(1'b1, c, d, ci, 8'(a), 8'(b));
          check(c ? "R6 R7 R11 sweep cmp" : "R8 R9 R10 sweep sbc",
                {acc_q, flag_n, flag_z, flag_c, flag_v}, exp);
          eacc = exp[11:4];
          ev   = exp[0];
        end
      end
    end

    // R1: reset mid-run clears everything again
    @(negedge clk);
    rst = 1'b1; valid = 1'b0;
    @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1 reset after use", {acc_q, flag_n, flag_z, flag_c, flag_v}, 12'h000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule